// File: doc/BRIEF.md
# Stored-Melody Tone Sequencer

This block turns a free-running system clock into eight square-wave musical tones covering one C-major octave. It has two ways of playing them.

In keyboard play, each of eight level switches gates its own tone onto its own output pin. Several pins can sound together, and an external mixer adds them.

In melody play, holding one of four select buttons replays a stored melody. Each melody is a sequence of 4-bit step codes. A step lasts one sixteenth of a second, and a longer note is written by repeating the same code over several steps. The step index is advanced from a 16 Hz level signal, once per high phase of that signal. The current step's code is decoded into a single tone on output pin 0. Releasing every button returns the block to keyboard play.

All tone and step-rate dividers are derived from a clock-frequency parameter, so a scaled-down clock gives the same behaviour in fewer cycles.

Top module: `tone_melody_seq`

## Requirements
- R1: Tone k (k = 0..7, nominal 262, 294, 330, 349, 392, 440, 494, 523 Hz) toggles every CLK_HZ/(2·f) clock cycles (integer division), which is a divider value of CLK_HZ/(2·f) − 1.
- R2: In keyboard play, output pin k, one register after the inputs, carries tone k while switch k is 1 and is held low while switch k is 0.
- R3: Buttons pass through a two-flop synchronizer. Any pressed button selects melody play, and when several are pressed the lowest-numbered button picks the melody.
- R4: In melody play, pins 7..1 stay low.
- R5: Step code c in 1..8 drives tone c−1 (1 = C4 up to 8 = C5) on pin 0. Code 0 and codes 9..15 are rests, and pin 0 stays low during a rest.
- R6: The step index advances at most once per high phase of the 16 Hz level, so a step lasts CLK_HZ/16 cycles.
- R7: Entering melody play, or changing to another melody, sets the step index to 0 and restarts the 16 Hz phase, so step 0 lasts a full step.
- R8: Melodies 0..3 are 8, 43, 112 and 183 steps long. After the last step the index wraps to 0 and the melody repeats while the button is held.
- R9: Melody 0 step i holds code i+1. Melody s (s = 1..3) step i holds code ((i div 4)·(2s+1)) mod 10.
- R10: Releasing all buttons returns the block to keyboard play.
- R11: During and straight after reset all output pins are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLK_HZ nominal |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 4 | Melody select buttons, asynchronous, active high |
| sw_i | input | 8 | Keyboard note switches, one per tone |
| tone_o | output | 8 | Registered square-wave outputs, one pin per tone |

## Verification
The bound checker watches the following on every cycle:
- pins 7..1 are quiet in melody play, and in keyboard play no pin is active whose switch is off;
- the step index stays inside the current melody's length;
- the step index changes only by an advance or a restart, and there are never two advances back to back;
- a restart always leaves index 0.

Only the bench scenarios can show the rest:
- which tone each code produces and the real half-periods on the pins;
- that the melody contents come out in order;
- the wrap back to the first note, and the lowest-button priority;
- that a step lasts a full sixteenth after a restart.

// File: rtl/melody_pkg.sv
package melody_pkg;

    localparam int NUM_NOTES  = 8;
    localparam int NUM_SONGS  = 4;
    localparam int CODE_W     = 4;
    localparam int SONG_W     = $clog2(NUM_SONGS);
    localparam int NOTE_IDX_W = $clog2(NUM_NOTES);
    localparam int MAX_LEN    = 183;
    localparam int STEP_W     = $clog2(MAX_LEN + 1);

    // Nominal tone frequencies, C4 up to C5 of the C-major scale
    localparam int unsigned NOTE_HZ [NUM_NOTES] =
        '{262, 294, 330, 349, 392, 440, 494, 523};

    typedef logic [CODE_W-1:0] step_code_t;
    typedef logic [STEP_W-1:0] step_idx_t;

    typedef enum logic {
        MODE_PIANO = 1'b0,
        MODE_SONG  = 1'b1
    } play_mode_e;

    typedef struct packed {
        play_mode_e        mode;
        logic [SONG_W-1:0] song;
    } play_sel_t;

    typedef struct packed {
        logic                  audible;
        logic [NOTE_IDX_W-1:0] idx;
    } note_pick_t;

    // Divider limit for a square wave of freq_hz from clk_hz
    function automatic int unsigned half_div(int unsigned clk_hz, int unsigned freq_hz);
        return clk_hz / (2 * freq_hz) - 1;
    endfunction

    function automatic step_idx_t song_len(logic [SONG_W-1:0] song);
        case (song)
            2'd0:    return step_idx_t'(8);
            2'd1:    return step_idx_t'(43);
            2'd2:    return step_idx_t'(112);
            default: return step_idx_t'(183);
        endcase
    endfunction

    // Melody contents computed rather than stored as a literal table
    function automatic step_code_t song_entry(logic [SONG_W-1:0] song, step_idx_t idx);
        int unsigned blk;
        int unsigned mul;
        if (song == '0) begin
            return step_code_t'(int'(idx) + 1);
        end
        blk = int'(idx) / 4;
        mul = 2 * int'(song) + 1;
        return step_code_t'((blk * mul) % 10);
    endfunction

    function automatic note_pick_t decode_code(step_code_t code);
        note_pick_t p;
        p.audible = (code >= 4'd1) && (code <= 4'd8);
        p.idx     = p.audible ? NOTE_IDX_W'(code - 4'd1) : '0;
        return p;
    endfunction

endpackage

// File: rtl/tone_div.sv
module tone_div #(
    parameter int unsigned DIV        = 10,
    parameter bit          PRESET_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic preset,
    output logic wave
);
    localparam int W = $clog2(DIV + 2);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            wave <= 1'b0;
        end else if (preset) begin
            cnt  <= '0;
            wave <= PRESET_LVL;
        end else if (cnt == W'(DIV)) begin
            cnt  <= '0;
            wave <= ~wave;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/song_select.sv
module song_select
    import melody_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SONGS-1:0] btn_i,
    output play_sel_t            cur,
    output logic                 restart
);
    logic [NUM_SONGS-1:0] btn_m;
    logic [NUM_SONGS-1:0] btn_s;
    play_sel_t            prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            btn_m <= '0;
            btn_s <= '0;
        end else begin
            btn_m <= btn_i;
            btn_s <= btn_m;
        end
    end

    // Scan from the top down so the lowest pressed button is written last
    always_comb begin
        cur.mode = MODE_PIANO;
        cur.song = '0;
        for (int i = NUM_SONGS - 1; i >= 0; i--) begin
            if (btn_s[i]) begin
                cur.mode = MODE_SONG;
                cur.song = SONG_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev.mode <= MODE_PIANO;
            prev.song <= '0;
        end else begin
            prev <= cur;
        end
    end

    assign restart = (cur.mode == MODE_PIANO) || (prev.mode == MODE_PIANO) ||
                     (cur.song != prev.song);
endmodule

// File: rtl/song_stepper.sv
module song_stepper
    import melody_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      tick_lvl,
    input  step_idx_t len,
    output step_idx_t step,
    output logic      adv
);
    logic done_hi;

    assign adv = tick_lvl && !done_hi && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            step    <= '0;
            done_hi <= 1'b0;
        end else if (restart) begin
            step    <= '0;
            done_hi <= 1'b1;
        end else if (adv) begin
            done_hi <= 1'b1;
            step    <= (step == len - 1'b1) ? '0 : step + 1'b1;
        end else if (!tick_lvl) begin
            done_hi <= 1'b0;
        end
    end
endmodule

// File: rtl/tone_melody_seq.sv
module tone_melody_seq
    import melody_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 25_000_000,
    parameter int unsigned STEP_HZ = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SONGS-1:0] btn_i,
    input  logic [NUM_NOTES-1:0] sw_i,
    output logic [NUM_NOTES-1:0] tone_o
);
    localparam int unsigned TICK_DIV = half_div(CLK_HZ, STEP_HZ);

    logic [NUM_NOTES-1:0] note_wave;
    logic                 tick_lvl;
    play_sel_t            sel;
    play_mode_e           cur_mode;
    logic                 restart;
    logic                 step_adv;
    step_idx_t            step_idx;
    step_idx_t            cur_len;
    note_pick_t           pick;
    logic [NUM_NOTES-1:0] tone_q;

    for (genvar g = 0; g < NUM_NOTES; g++) begin : g_note
        tone_div #(
            .DIV       (half_div(CLK_HZ, NOTE_HZ[g])),
            .PRESET_LVL(1'b0)
        ) u_div (
            .clk   (clk),
            .rst   (rst),
            .preset(1'b0),
            .wave  (note_wave[g])
        );
    end

    tone_div #(
        .DIV       (TICK_DIV),
        .PRESET_LVL(1'b1)
    ) u_tick (
        .clk   (clk),
        .rst   (rst),
        .preset(restart),
        .wave  (tick_lvl)
    );

    song_select u_sel (
        .clk    (clk),
        .rst    (rst),
        .btn_i  (btn_i),
        .cur    (sel),
        .restart(restart)
    );

    assign cur_mode = sel.mode;
    assign cur_len  = song_len(sel.song);

    song_stepper u_step (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick_lvl(tick_lvl),
        .len     (cur_len),
        .step    (step_idx),
        .adv     (step_adv)
    );

    assign pick = decode_code(song_entry(sel.song, step_idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            tone_q <= '0;
        end else if (cur_mode == MODE_PIANO) begin
            tone_q <= sw_i & note_wave;
        end else begin
            tone_q <= {{(NUM_NOTES-1){1'b0}}, pick.audible & note_wave[pick.idx]};
        end
    end

    assign tone_o = tone_q;
endmodule

// File: rtl/melody_chk.sv
module melody_chk
    import melody_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input play_mode_e           cur_mode,
    input logic                 restart,
    input logic                 step_adv,
    input step_idx_t            step_idx,
    input step_idx_t            cur_len,
    input logic [NUM_NOTES-1:0] sw_i,
    input logic [NUM_NOTES-1:0] tone_o
);
    // R4
    song_pins_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cur_mode == MODE_SONG) |-> (tone_o[NUM_NOTES-1:1] == '0));

    // R2
    piano_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cur_mode == MODE_PIANO) |-> ((tone_o & ~$past(sw_i)) == '0));

    // R8
    step_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        !restart |-> (step_idx < cur_len));

    // R6
    single_adv_chk: assert property (@(posedge clk) disable iff (rst)
        step_adv |=> !step_adv);

    // R6
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!restart && !step_adv) |=> $stable(step_idx));

    // R8
    step_next_chk: assert property (@(posedge clk) disable iff (rst)
        step_adv |=> ((step_idx == $past(step_idx) + 1'b1) || (step_idx == '0)));

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (step_idx == '0));
endmodule

bind tone_melody_seq melody_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cur_mode(cur_mode),
    .restart (restart),
    .step_adv(step_adv),
    .step_idx(step_idx),
    .cur_len (cur_len),
    .sw_i    (sw_i),
    .tone_o  (tone_o)
);

// File: tb/sim_tone_melody_seq.sv
module sim_tone_melody_seq;

    localparam int CLK_HZ   = 8000;
    localparam int STEP_CYC = CLK_HZ / 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] btn = '0;
    logic [7:0] sw  = '0;
    logic [7:0] tone_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    bit mon_song = 1'b0;
    int hi_bad = 0;
    int got [64];
    int got_n;
    int expv [64];
    int exp_n;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (mon_song && tone_o[7:1] != 0) hi_bad++;

    tone_melody_seq #(.CLK_HZ(CLK_HZ)) u0 (
        .clk   (clk),
        .rst   (rst),
        .btn_i (btn),
        .sw_i  (sw),
        .tone_o(tone_o)
    );

    function automatic int freq_of(int k);
        case (k)
            0: return 262; 1: return 294; 2: return 330; 3: return 349;
            4: return 392; 5: return 440; 6: return 494; default: return 523;
        endcase
    endfunction

    // R1: expected half-period in cycles
    function automatic int half_exp(int k);
        return CLK_HZ / (2 * freq_of(k));
    endfunction

    function automatic int len_of(int s);
        case (s)
            0: return 8; 1: return 43; 2: return 112; default: return 183;
        endcase
    endfunction

    // R9 contents, R5 mapping (0 = rest class)
    function automatic int exp_class(int s, int i);
        int c;
        int j;
        j = i % len_of(s);
        c = (s == 0) ? j + 1 : ((j / 4) * (2 * s + 1)) % 10;
        return (c >= 1 && c <= 8) ? c : 0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expd);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expd);
        end
    endtask

    // Returns 1..8 for a recognised tone, 0 for a steady low, -1 if unclear
    task automatic measure(input int pin, output int code);
        logic v;
        int w;
        int h1;
        int h2;
        code = -1;
        @(negedge clk);
        v = tone_o[pin];
        w = 0;
        while (w < 40 && tone_o[pin] == v) begin @(negedge clk); w++; end
        if (tone_o[pin] == v) begin
            code = v ? -1 : 0;
            return;
        end
        v = tone_o[pin]; h1 = 0;
        while (h1 < 40 && tone_o[pin] == v) begin @(negedge clk); h1++; end
        v = tone_o[pin]; h2 = 0;
        while (h2 < 40 && tone_o[pin] == v) begin @(negedge clk); h2++; end
        if (h1 != h2) return;
        for (int k = 0; k < 8; k++) if (half_exp(k) == h1) code = k + 1;
    endtask

    task automatic capture(input int dur);
        int t0;
        int code;
        got_n = 0;
        t0 = cyc;
        while (cyc - t0 < dur) begin
            measure(0, code);
            if (code >= 0 && (got_n == 0 || got[got_n-1] != code)) begin
                if (got_n < 64) got[got_n] = code;
                got_n++;
            end
        end
    endtask

    task automatic build_exp(input int s, input int first, input int nsteps);
        int c;
        exp_n = 0;
        for (int i = first; i < first + nsteps; i++) begin
            c = exp_class(s, i);
            if (exp_n == 0 || expv[exp_n-1] != c) begin
                if (exp_n < 64) expv[exp_n] = c;
                exp_n++;
            end
        end
    endtask

    task automatic compare_seq(input string req, input string what);
        int bad;
        int act;
        int expd;
        bad = -1;
        if (got_n != exp_n) bad = 0;
        else for (int i = 0; i < exp_n && i < 64; i++) if (bad < 0 && got[i] != expv[i]) bad = i;
        act  = (bad < 0) ? 0 : ((got_n != exp_n) ? got_n : got[bad]);
        expd = (bad < 0) ? 0 : ((got_n != exp_n) ? exp_n : expv[bad]);
        check(bad < 0, req, what, act, expd);
    endtask

    task automatic play(input logic [3:0] b, input int s, input int nsteps,
                        input string req, input string what);
        btn = b;
        repeat (6) @(negedge clk);
        mon_song = 1'b1;
        hi_bad = 0;
        capture(nsteps * STEP_CYC - 256);
        mon_song = 1'b0;
        build_exp(s, 0, nsteps);
        compare_seq(req, what);
        check(hi_bad == 0, "R4", "upper pins quiet in melody play", hi_bad, 0);
    endtask

    task automatic piano_check(input string req);
        int code;
        repeat (4) @(negedge clk);
        for (int p = 0; p < 8; p++) begin
            measure(p, code);
            // R1 half-period, R2 gating
            check(code == (sw[p] ? p + 1 : 0), req, $sformatf("pin %0d sw=%0b", p, sw[p]),
                  code, sw[p] ? p + 1 : 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int code;
        void'($urandom(32'd4242));
        sw = 8'hFF;
        btn = 4'b0001;
        repeat (5) @(negedge clk);
        // R11: outputs low while in reset
        check(tone_o == 8'h00, "R11", "outputs during reset", tone_o, 0);
        rst = 1'b0;
        btn = '0;
        sw  = '0;
        @(negedge clk);
        check(tone_o == 8'h00, "R11", "outputs after reset", tone_o, 0);

        // R1 R2: directed all-on, then random patterns
        sw = 8'hFF;
        piano_check("R1");
        for (int n = 0; n < 8; n++) begin
            sw = 8'($urandom);
            piano_check("R2");
        end
        sw = '0;

        // R9 R5 R8: melody 0 scale plus wrap to the first note
        play(4'b0001, 0, 9, "R8", "melody 0 scale and wrap");
        btn = '0; repeat (10) @(negedge clk);

        // R5 R8 R9: melody 1 with rests and codes 9, wrapping
        play(4'b0010, 1, 45, "R9", "melody 1 sequence");
        btn = '0; repeat (10) @(negedge clk);

        // R3: two buttons, lowest wins
        play(4'b1010, 1, 12, "R3", "priority of button 1 over 3");
        btn = '0; repeat (10) @(negedge clk);

        // R5: melody 3 reaches F (code 4)
        play(4'b1000, 3, 12, "R5", "melody 3 opening with F");

        // R7: change melody without release restarts at step 0
        btn = 4'b0100;
        repeat (6 * STEP_CYC) @(negedge clk);
        play(4'b0001, 0, 3, "R7", "restart on melody change");
        btn = '0; repeat (10) @(negedge clk);

        // R6 R7: step 0 lasts a full step
        btn = 4'b0001;
        repeat (440) @(negedge clk);
        measure(0, code);
        check(code == 1, "R6", "still step 0 before one step time", code, 1);
        repeat (100) @(negedge clk);
        measure(0, code);
        check(code == 2, "R6", "step 1 after one step time", code, 2);

        // R10: release returns to keyboard play
        sw = 8'b1010_0110;
        btn = '0;
        repeat (6) @(negedge clk);
        piano_check("R10");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule